// File: doc/BRIEF.md
# Asynchronous Memory Read Strobe Generator

This block runs read cycles on one chip select of an external asynchronous static memory. An internal client raises a one-cycle request with an address and byte enables. The block then drives the address and active-low byte selects onto the memory pins and produces two active-low strobes, a chip select and a read enable. Each strobe has its own setup length and pulse length, counted in clock cycles. Both strobes share one read-cycle length. The 16-bit data bus is captured on one clock edge, and the captured word is returned with a one-cycle ready pulse.

The two strobe waveforms are built independently of each other. A capture-select input decides which strobe's release edge samples the bus. The block never compares the two strobes' timings to make that choice. Timing inputs are read only on the clock edge that starts an access, so the client may reprogram them at any time. Illegal programming, either a zero pulse or a read-cycle length shorter than a strobe, is repaired and reported on a configuration-error output.

Top module: `sram_rd_strobe`

## Requirements
- R1: After reset, mem_cs_n and mem_rd_n are 1, req_rdy is 0 and cfg_err is 0.
- R2: Cycle index 0 is the clock period that starts at the edge sampling an accepted request. Each strobe is low from index equal to its setup for exactly its pulse length, and high at all other times. With zero setup it is low in index 0, together with the new address.
- R3: With cfg_cap_on_rd = 1, req_data is the bus value sampled on the edge that drives mem_rd_n high, whatever mem_cs_n does.
- R4: With cfg_cap_on_rd = 0, req_data is the bus value sampled on the edge that drives mem_cs_n high, even when mem_rd_n is already high by then.
- R5: mem_addr equals the request address and mem_be_n equals the bitwise inverse of req_be during every cycle of the access and in its ready cycle.
- R6: req_rdy is high for exactly one cycle, at index L. L is cfg_cycle when cfg_cycle is at least setup plus pulse of both strobes.
- R7: When cfg_cycle is below setup plus pulse of either strobe, L becomes the larger of the two sums and cfg_err is 1 for that access. Otherwise cfg_err is 0.
- R8: A pulse programmed as 0 behaves as a pulse of 1 and sets cfg_err for that access.
- R9: A request raised while an access is running is ignored. A request raised during the ready cycle starts the next access on the following edge.
- R10: Timing inputs and cfg_cap_on_rd are sampled only when an access starts. A change during an access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when idle |
| req_addr | input | ADDR_W | Read address |
| req_be | input | BS_W | Byte enables, 1 = byte wanted |
| cfg_cs_setup | input | CNT_W | Chip-select setup cycles |
| cfg_cs_pulse | input | CNT_W | Chip-select low cycles |
| cfg_rd_setup | input | CNT_W | Read-enable setup cycles |
| cfg_rd_pulse | input | CNT_W | Read-enable low cycles |
| cfg_cycle | input | CNT_W | Read-cycle length in cycles |
| cfg_cap_on_rd | input | 1 | 1 = capture on read-enable release, 0 = on chip-select release |
| req_rdy | output | 1 | One-cycle completion pulse |
| req_data | output | DATA_W | Captured read data |
| cfg_err | output | 1 | Programming of the current/last access was repaired |
| mem_addr | output | ADDR_W | Memory address |
| mem_be_n | output | BS_W | Active-low byte selects |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_rd_n | output | 1 | Active-low read enable |
| mem_dq | input | DATA_W | Memory data bus |

## Verification
The memory model drives a pattern derived from the address only while the read enable is low, and drives zero otherwise. A capture on the wrong edge therefore shows up as a wrong word. The timing table covers several cases: strobes that release together, a read enable that releases before the chip select in each capture mode, and a chip select that releases while the read enable is still low. It also has a chip select that releases after the read enable has gone high, which separates the two capture modes. Other entries use a cycle shorter than a strobe, a zero pulse, and a long read pulse under a short chip select. Directed runs inject a request and a timing change in the middle of an access, then chain a second access from the ready cycle. These runs show that both are ignored until the next start.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic {
    CAP_ON_CS = 1'b0,
    CAP_ON_RD = 1'b1
  } cap_sel_e;

  localparam int STB_CS  = 0;
  localparam int STB_RD  = 1;
  localparam int NUM_STB = 2;
endpackage

// File: rtl/srd_cfg_latch.sv
module srd_cfg_latch
  import srd_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LEN_W = CNT_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [NUM_STB-1:0][CNT_W-1:0]    in_setup,
  input  logic [NUM_STB-1:0][CNT_W-1:0]    in_pulse,
  input  logic [CNT_W-1:0]                 in_cycle,
  input  cap_sel_e                         in_mode,
  output logic [NUM_STB-1:0][CNT_W-1:0]    setup_d,
  output logic [NUM_STB-1:0][CNT_W-1:0]    pulse_d,
  output logic [NUM_STB-1:0][CNT_W-1:0]    setup_q,
  output logic [NUM_STB-1:0][CNT_W-1:0]    pulse_q,
  output logic [LEN_W-1:0]                 len_q,
  output cap_sel_e                         mode_q,
  output logic                             err_q
);

  logic [NUM_STB-1:0][CNT_W-1:0] pulse_fix;
  logic [NUM_STB-1:0][LEN_W-1:0] span;
  logic [NUM_STB-1:0]            zero_p;
  logic [NUM_STB-1:0]            too_short;
  logic [LEN_W-1:0]              len_in;
  logic [LEN_W-1:0]              len_nxt;
  cap_sel_e                      mode_nxt;
  logic                          err_in;
  logic                          err_nxt;

  // per-strobe repair of the programmed values
  for (genvar i = 0; i < NUM_STB; i++) begin : g_fix
    always_comb begin
      zero_p[i]    = (in_pulse[i] == '0);
      pulse_fix[i] = zero_p[i] ? CNT_W'(1) : in_pulse[i];
      span[i]      = LEN_W'(in_setup[i]) + LEN_W'(pulse_fix[i]);
      too_short[i] = (LEN_W'(in_cycle) < span[i]);
    end
  end

  always_comb begin
    len_in = LEN_W'(in_cycle);
    for (int i = 0; i < NUM_STB; i++) begin
      if (span[i] > len_in) len_in = span[i];
    end
    err_in = (|zero_p) | (|too_short);
  end

  // next-state: load only on the start edge
  always_comb begin
    setup_d  = start ? in_setup  : setup_q;
    pulse_d  = start ? pulse_fix : pulse_q;
    len_nxt  = start ? len_in    : len_q;
    mode_nxt = start ? in_mode   : mode_q;
    err_nxt  = start ? err_in    : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      pulse_q <= {NUM_STB{CNT_W'(1)}};
      len_q   <= LEN_W'(1);
      mode_q  <= CAP_ON_RD;
      err_q   <= 1'b0;
    end else begin
      setup_q <= setup_d;
      pulse_q <= pulse_d;
      len_q   <= len_nxt;
      mode_q  <= mode_nxt;
      err_q   <= err_nxt;
    end
  end

  for (genvar i = 0; i < NUM_STB; i++) begin : g_chk
    AST_SPAN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (LEN_W'(setup_q[i]) + LEN_W'(pulse_q[i])) <= len_q); // R7
    AST_PULSE_REPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) && ($past(in_pulse[i]) == '0) |-> err_q); // R8
  end

endmodule

// File: rtl/srd_seq.sv
module srd_seq #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LEN_W-1:0] len_q,
  output logic             start,
  output logic             busy,
  output logic [LEN_W-1:0] cnt,
  output logic             busy_nxt,
  output logic [LEN_W-1:0] cnt_nxt,
  output logic             rdy
);

  logic last;
  logic rdy_nxt;

  always_comb begin
    start    = req & ~busy;
    last     = busy & (cnt == (len_q - LEN_W'(1)));
    busy_nxt = start | (busy & ~last);
    if (start) begin
      cnt_nxt = '0;
    end else if (busy & ~last) begin
      cnt_nxt = cnt + LEN_W'(1);
    end else begin
      cnt_nxt = cnt;
    end
    rdy_nxt = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      rdy  <= 1'b0;
    end else begin
      busy <= busy_nxt;
      cnt  <= cnt_nxt;
      rdy  <= rdy_nxt;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len_q)); // R6
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy); // R6
  AST_RDY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !busy); // R9

endmodule

// File: rtl/srd_strobe.sv
module srd_strobe #(
  parameter int CNT_W = 6,
  parameter int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [LEN_W-1:0] cnt,
  input  logic             busy_nxt,
  input  logic [LEN_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] setup_d,
  input  logic [CNT_W-1:0] pulse_d,
  input  logic [CNT_W-1:0] setup_q,
  input  logic [CNT_W-1:0] pulse_q,
  output logic             strobe_n,
  output logic             release_edge
);

  logic [LEN_W-1:0] lo_d;
  logic [LEN_W-1:0] hi_d;
  logic [LEN_W-1:0] end_q;
  logic             on_nxt;

  always_comb begin
    lo_d         = LEN_W'(setup_d);
    hi_d         = LEN_W'(setup_d) + LEN_W'(pulse_d);
    on_nxt       = busy_nxt & (cnt_nxt >= lo_d) & (cnt_nxt < hi_d);
    end_q        = LEN_W'(setup_q) + LEN_W'(pulse_q) - LEN_W'(1);
    release_edge = busy & (cnt == end_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_n <= 1'b1;
    end else begin
      strobe_n <= ~on_nxt;
    end
  end

  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> strobe_n); // R2
  AST_LOW_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    release_edge |-> !strobe_n); // R2
  AST_HIGH_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    release_edge |=> strobe_n); // R2

endmodule

// File: rtl/sram_rd_strobe.sv
module sram_rd_strobe
  import srd_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int BS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BS_W-1:0]   req_be,
  input  logic [CNT_W-1:0]  cfg_cs_setup,
  input  logic [CNT_W-1:0]  cfg_cs_pulse,
  input  logic [CNT_W-1:0]  cfg_rd_setup,
  input  logic [CNT_W-1:0]  cfg_rd_pulse,
  input  logic [CNT_W-1:0]  cfg_cycle,
  input  logic              cfg_cap_on_rd,
  output logic              req_rdy,
  output logic [DATA_W-1:0] req_data,
  output logic              cfg_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BS_W-1:0]   mem_be_n,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam int LEN_W = CNT_W + 1;

  logic rst_meta;
  logic rst_n_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic [NUM_STB-1:0][CNT_W-1:0] in_setup;
  logic [NUM_STB-1:0][CNT_W-1:0] in_pulse;
  logic [NUM_STB-1:0][CNT_W-1:0] setup_d;
  logic [NUM_STB-1:0][CNT_W-1:0] pulse_d;
  logic [NUM_STB-1:0][CNT_W-1:0] setup_q;
  logic [NUM_STB-1:0][CNT_W-1:0] pulse_q;
  logic [LEN_W-1:0]              len_q;
  cap_sel_e                      mode_q;
  logic                          start;
  logic                          busy;
  logic                          busy_nxt;
  logic [LEN_W-1:0]              cnt;
  logic [LEN_W-1:0]              cnt_nxt;
  logic [NUM_STB-1:0]            stb_n;
  logic [NUM_STB-1:0]            rel;
  logic                          cap;
  logic [ADDR_W-1:0]             addr_nxt;
  logic [BS_W-1:0]               be_n_nxt;
  logic [DATA_W-1:0]             data_nxt;

  always_comb begin
    in_setup[STB_CS] = cfg_cs_setup;
    in_setup[STB_RD] = cfg_rd_setup;
    in_pulse[STB_CS] = cfg_cs_pulse;
    in_pulse[STB_RD] = cfg_rd_pulse;
  end

  srd_cfg_latch #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .in_setup (in_setup),
    .in_pulse (in_pulse),
    .in_cycle (cfg_cycle),
    .in_mode  (cap_sel_e'(cfg_cap_on_rd)),
    .setup_d  (setup_d),
    .pulse_d  (pulse_d),
    .setup_q  (setup_q),
    .pulse_q  (pulse_q),
    .len_q    (len_q),
    .mode_q   (mode_q),
    .err_q    (cfg_err)
  );

  srd_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .req      (req),
    .len_q    (len_q),
    .start    (start),
    .busy     (busy),
    .cnt      (cnt),
    .busy_nxt (busy_nxt),
    .cnt_nxt  (cnt_nxt),
    .rdy      (req_rdy)
  );

  for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
    srd_strobe #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stb (
      .clk          (clk),
      .rst_n        (rst_n_s),
      .busy         (busy),
      .cnt          (cnt),
      .busy_nxt     (busy_nxt),
      .cnt_nxt      (cnt_nxt),
      .setup_d      (setup_d[i]),
      .pulse_d      (pulse_d[i]),
      .setup_q      (setup_q[i]),
      .pulse_q      (pulse_q[i]),
      .strobe_n     (stb_n[i]),
      .release_edge (rel[i])
    );
  end

  assign mem_cs_n = stb_n[STB_CS];
  assign mem_rd_n = stb_n[STB_RD];

  // capture edge chosen by the mode bit alone
  always_comb begin
    cap      = (mode_q == CAP_ON_RD) ? rel[STB_RD] : rel[STB_CS];
    addr_nxt = start ? req_addr : mem_addr;
    be_n_nxt = start ? ~req_be  : mem_be_n;
    data_nxt = cap   ? mem_dq   : req_data;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mem_addr <= '0;
      mem_be_n <= '1;
      req_data <= '0;
    end else begin
      mem_addr <= addr_nxt;
      mem_be_n <= be_n_nxt;
      req_data <= data_nxt;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy && $past(busy) |-> $stable(mem_addr) && $stable(mem_be_n)); // R5
  AST_RD_CAPTURE_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    cap && (mode_q == CAP_ON_RD) |-> !mem_rd_n); // R3
  AST_CS_CAPTURE_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    cap && (mode_q == CAP_ON_CS) |-> !mem_cs_n); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy && $past(busy) |-> $stable(cfg_err) && $stable(mode_q)); // R10
  AST_RDY_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_rdy |-> mem_cs_n && mem_rd_n); // R6

endmodule

// File: tb/sim_sram_rd_strobe.sv
`timescale 1ns/1ps
module sim_sram_rd_strobe;

  localparam int CNT_W  = 6;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 24;
  localparam int BS_W   = 2;

  logic              clk;
  logic              rst_n;
  logic              req;
  logic [ADDR_W-1:0] req_addr;
  logic [BS_W-1:0]   req_be;
  logic [CNT_W-1:0]  cfg_cs_setup, cfg_cs_pulse, cfg_rd_setup, cfg_rd_pulse, cfg_cycle;
  logic              cfg_cap_on_rd;
  logic              req_rdy;
  logic [DATA_W-1:0] req_data;
  logic              cfg_err;
  logic [ADDR_W-1:0] mem_addr;
  logic [BS_W-1:0]   mem_be_n;
  logic              mem_cs_n, mem_rd_n;
  logic [DATA_W-1:0] mem_dq;

  int n_chk;
  int n_bad;

  sram_rd_strobe #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BS_W(BS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_be(req_be),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse),
    .cfg_cycle(cfg_cycle), .cfg_cap_on_rd(cfg_cap_on_rd),
    .req_rdy(req_rdy), .req_data(req_data), .cfg_err(cfg_err),
    .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_dq(mem_dq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // memory drives the word only while read enable is low
  assign mem_dq = !mem_rd_n ? pat(mem_addr) : '0;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0] cs_s, cs_p, rd_s, rd_p, cyc;
    logic       mode;
    logic [6:0] exp_len;
    logic       exp_err;
    logic       exp_valid;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'd0, 6'd4, 6'd0, 6'd4, 6'd5,  1'b1, 7'd5,  1'b0, 1'b1},
    '{6'd1, 6'd5, 6'd2, 6'd2, 6'd8,  1'b1, 7'd8,  1'b0, 1'b1},
    '{6'd1, 6'd5, 6'd2, 6'd2, 6'd8,  1'b0, 7'd8,  1'b0, 1'b0},
    '{6'd0, 6'd3, 6'd1, 6'd4, 6'd4,  1'b0, 7'd5,  1'b1, 1'b1},
    '{6'd2, 6'd1, 6'd0, 6'd6, 6'd10, 1'b1, 7'd10, 1'b0, 1'b1},
    '{6'd0, 6'd0, 6'd0, 6'd1, 6'd3,  1'b0, 7'd3,  1'b1, 1'b1},
    '{6'd3, 6'd2, 6'd0, 6'd2, 6'd4,  1'b0, 7'd5,  1'b1, 1'b0}
  };

  int          g_len, g_cs_cnt, g_cs_first, g_rd_cnt, g_rd_first;
  logic [15:0] g_data;
  logic        g_err;
  bit          g_addr_ok;

  // issue one read at a negedge and watch it until ready; ends at the ready negedge
  task automatic do_access(input logic [ADDR_W-1:0] a, input logic [BS_W-1:0] be,
                           input bit disturb);
    req = 1'b1; req_addr = a; req_be = be;
    g_len = -1; g_cs_cnt = 0; g_cs_first = -1; g_rd_cnt = 0; g_rd_first = -1;
    g_addr_ok = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (mem_addr != a || mem_be_n != ~be) g_addr_ok = 1'b0;
      if (req_rdy) begin
        g_len = i; g_data = req_data; g_err = cfg_err;
        if (!mem_cs_n || !mem_rd_n) g_addr_ok = 1'b0;
        break;
      end
      if (!mem_cs_n) begin g_cs_cnt++; if (g_cs_first < 0) g_cs_first = i; end
      if (!mem_rd_n) begin g_rd_cnt++; if (g_rd_first < 0) g_rd_first = i; end
      if (disturb && i == 1) begin
        req = 1'b1; req_addr = ~a; req_be = ~be; cfg_cycle = 6'd40;
        cfg_cap_on_rd = ~cfg_cap_on_rd;
      end
      if (disturb && i == 2) begin
        req = 1'b0; req_addr = a; req_be = be; cfg_cap_on_rd = ~cfg_cap_on_rd;
      end
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_cs_setup = v.cs_s; cfg_cs_pulse = v.cs_p;
    cfg_rd_setup = v.rd_s; cfg_rd_pulse = v.rd_p;
    cfg_cycle = v.cyc; cfg_cap_on_rd = v.mode;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    req = 1'b0; req_addr = '0; req_be = '0;
    set_cfg(VECS[0]);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 rd_n", mem_rd_n, 1);
    chk("R1 rdy", req_rdy, 0);
    chk("R1 cfg_err", cfg_err, 0);

    // table of timing vectors
    foreach (VECS[k]) begin
      logic [ADDR_W-1:0] a;
      int cp, rp;
      a = 24'h100000 + 24'(k) * 24'h1111;
      set_cfg(VECS[k]);
      cp = (VECS[k].cs_p == 0) ? 1 : int'(VECS[k].cs_p);
      rp = (VECS[k].rd_p == 0) ? 1 : int'(VECS[k].rd_p);
      do_access(a, 2'(k), 1'b0);
      chk("R6 R7 length", g_len, int'(VECS[k].exp_len));
      chk("R7 R8 cfg_err", int'(g_err), int'(VECS[k].exp_err));
      chk(VECS[k].mode ? "R3 data" : "R4 data", int'(g_data),
          VECS[k].exp_valid ? int'(pat(a)) : 0);
      chk("R2 R8 cs low cycles", g_cs_cnt, cp);
      chk("R2 cs first index", g_cs_first, int'(VECS[k].cs_s));
      chk("R2 rd low cycles", g_rd_cnt, rp);
      chk("R2 rd first index", g_rd_first, int'(VECS[k].rd_s));
      chk("R5 address and byte selects", int'(g_addr_ok), 1);
      @(negedge clk);
    end

    // R9 R10: request and timing change mid-access, then chained access
    set_cfg(VECS[1]);
    do_access(24'hABC123, 2'b01, 1'b1);
    chk("R10 length unchanged", g_len, 8);
    chk("R9 address kept", int'(g_addr_ok), 1);
    chk("R9 R3 data of first request", int'(g_data), int'(pat(24'hABC123)));
    do_access(24'h00F00D, 2'b11, 1'b0);
    chk("R9 chained start cs index", g_cs_first, 1);
    chk("R10 new cycle length", g_len, 40);
    chk("R10 data", int'(g_data), int'(pat(24'h00F00D)));

    // R9: ignored request left no second access behind
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!mem_cs_n || !mem_rd_n || req_rdy) lows++;
      end
      chk("R9 idle after ignored request", lows, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule